// File: doc/BRIEF.md
# MDIO Management Command Engine

This block runs a single management transaction, read or write, against an external PHY over the two-wire MDC/MDIO interface. Software fills a data register (for writes) and then writes a command word. The command word carries a 2-bit clock divide code, a 5-bit PHY address, a 5-bit register address, a write flag and a go bit. An accepted command raises `busy`. The engine then clocks out one serial frame and lowers `busy` when the frame is complete. For a read, the 16 bits returned by the PHY are in the data register once `busy` has dropped.

MDC runs only while a transaction is in flight. Its rate is the system clock divided by 16, 32, 64 or 128, as the divide code selects. Software should choose the smallest ratio that keeps MDC at or below 2.5 MHz. The engine changes the MDIO level only just after a falling MDC edge and samples the line on rising edges. It releases the line for the turnaround and data phases of a read.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset, `busy` is 0, `mdc` is low, `mdio_oe` is 0 and `data_rdata` is 0.
- R2: A `cmd_we` pulse with `cmd_go`=1 while idle sets `busy` on the next cycle. `busy` then stays high for exactly 64 × ratio clock cycles.
- R3: Divide code 0, 1, 2 and 3 gives a ratio of 16, 32, 64 and 128. The MDC period equals the ratio in clocks, and MDC is held low whenever `busy` is 0.
- R4: Each frame is 64 MDC bits, sent MSB first, in this order: 32 ones, start bits 01, opcode (10 for read, 01 for write), the 5-bit PHY address, the 5-bit register address, a turnaround of 10 and 16 data bits.
- R5: A `data_we` pulse while idle loads `data_wdata` into the data register. A write transaction sends that value as its data bits, drives MDIO for all 64 bits and leaves the data register unchanged.
- R6: A read drives MDIO for the first 46 bits and releases it for the last 18. It samples MDIO on each rising MDC edge of the 16 data bits. When `busy` clears, the data register holds those bits, with the first one received as bit 15.
- R7: A `cmd_we` pulse while `busy` is 1 is ignored. The frame in flight and its length do not change, and no second frame follows.
- R8: A `data_we` pulse while `busy` is 1 is ignored.
- R9: A `cmd_we` pulse with `cmd_go`=0 starts nothing.
- R10: The MDIO level changes only at a falling MDC edge, or when a frame starts, and is stable while MDC is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_go | input | 1 | Go bit of the command word; starts a transaction |
| cmd_wr | input | 1 | 1 selects a write, 0 a read |
| cmd_div | input | 2 | MDC divide code (0:16, 1:32, 2:64, 3:128) |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | PHY register address |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 16 | Data register write value |
| data_rdata | output | 16 | Data register contents |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output level |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input level |

## Verification
The assertions assume that `data_we` and `cmd_we` are single-cycle strobes and that `mdio_i` is a defined level whenever the engine has released the line. The bench meets the second assumption with a responder that idles at 1 (the pull-up level), drives 0 in the second turnaround bit and changes its output only just after a falling MDC edge. The bench writes strobes at falling clock edges and holds each one for a single cycle. It loads the data register at least one cycle before it issues the command.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   typedef enum logic [1:0] {
      MDIO_OP_WR = 2'b01,
      MDIO_OP_RD = 2'b10
   } mdio_op_e;

   localparam logic [1:0] MDIO_SOF = 2'b01;
   localparam logic [1:0] MDIO_TA  = 2'b10;

   function automatic int unsigned mdio_frame_len(int unsigned pre, int unsigned aw, int unsigned dw);
      return pre + 2 + 2 + 2 * aw + 2 + dw;
   endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int unsigned DIV_W     = 2,
   parameter int unsigned BASE_HALF = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise,
   output logic             fall
);
   localparam int unsigned MAX_HALF = BASE_HALF << ((1 << DIV_W) - 1);
   localparam int unsigned CNT_W    = $clog2(MAX_HALF);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] half_m1;
   logic             tick;

   always_comb begin
      half_m1 = CNT_W'((BASE_HALF << div) - 1);
      tick    = run && (cnt_q == half_m1);
      rise    = tick && !mdc;
      fall    = tick && mdc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (tick) begin
         cnt_q <= '0;
         mdc   <= ~mdc;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift
   import mdio_pkg::*;
#(
   parameter int unsigned PRE_LEN = 32,
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              active,
   input  logic              is_rd,
   input  logic [ADDR_W-1:0] phy,
   input  logic [ADDR_W-1:0] rga,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rise,
   input  logic              fall,
   input  logic              mdio_i,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic [DATA_W-1:0] rdata,
   output logic              done
);
   localparam int unsigned FRAME_LEN = mdio_frame_len(PRE_LEN, ADDR_W, DATA_W);
   localparam int unsigned BC_W      = $clog2(FRAME_LEN);
   localparam logic [BC_W-1:0] REL_IDX  = BC_W'(PRE_LEN + 4 + 2 * ADDR_W);
   localparam logic [BC_W-1:0] DAT_IDX  = BC_W'(PRE_LEN + 6 + 2 * ADDR_W);
   localparam logic [BC_W-1:0] LAST_IDX = BC_W'(FRAME_LEN - 1);

   logic [FRAME_LEN-1:0] sh_q;
   logic [BC_W-1:0]      bcnt_q;
   logic                 rd_q;
   logic [DATA_W-1:0]    rx_q;
   mdio_op_e             op;

   assign op      = is_rd ? MDIO_OP_RD : MDIO_OP_WR;
   assign mdio_o  = sh_q[FRAME_LEN-1];
   assign mdio_oe = active && (!rd_q || (bcnt_q < REL_IDX));
   assign done    = active && fall && (bcnt_q == LAST_IDX);
   assign rdata   = rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         bcnt_q <= '0;
         rd_q   <= 1'b0;
         rx_q   <= '0;
      end else if (start) begin
         sh_q   <= {{PRE_LEN{1'b1}}, MDIO_SOF, op, phy, rga, MDIO_TA,
                    (is_rd ? {DATA_W{1'b0}} : wdata)};
         bcnt_q <= '0;
         rd_q   <= is_rd;
      end else if (active) begin
         if (rise && rd_q && (bcnt_q >= DAT_IDX))
            rx_q <= {rx_q[DATA_W-2:0], mdio_i};
         if (fall && (bcnt_q != LAST_IDX)) begin
            bcnt_q <= bcnt_q + 1'b1;
            sh_q   <= {sh_q[FRAME_LEN-2:0], 1'b1};
         end
      end
   end
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine #(
   parameter int unsigned PRE_LEN   = 32,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned DIV_W     = 2,
   parameter int unsigned BASE_HALF = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic              cmd_go,
   input  logic              cmd_wr,
   input  logic [DIV_W-1:0]  cmd_div,
   input  logic [ADDR_W-1:0] cmd_phy,
   input  logic [ADDR_W-1:0] cmd_reg,
   input  logic              data_we,
   input  logic [DATA_W-1:0] data_wdata,
   output logic [DATA_W-1:0] data_rdata,
   output logic              busy,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   generate
      if (PRE_LEN < 1 || ADDR_W < 1 || DATA_W < 2 || DIV_W < 1 || BASE_HALF < 2) begin : g_bad_cfg
         $error("mdio_cmd_engine: illegal parameter set");
      end
   endgenerate

   logic              busy_q;
   logic              wr_q;
   logic [DIV_W-1:0]  div_q;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] rx_data;
   logic [DATA_W-1:0] load_data;
   logic              accept;
   logic              done;
   logic              rise;
   logic              fall;

   assign accept    = cmd_we && cmd_go && !busy_q;
   assign load_data = data_we ? data_wdata : data_q;
   assign busy       = busy_q;
   assign data_rdata = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         wr_q   <= 1'b0;
         div_q  <= '0;
         data_q <= '0;
      end else begin
         if (accept) begin
            busy_q <= 1'b1;
            wr_q   <= cmd_wr;
            div_q  <= cmd_div;
         end else if (done) begin
            busy_q <= 1'b0;
         end
         if (data_we && !busy_q)
            data_q <= data_wdata;
         else if (done && !wr_q)
            data_q <= rx_data;
      end
   end

   mdio_clk_div #(.DIV_W(DIV_W), .BASE_HALF(BASE_HALF)) u_clk (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy_q),
      .div  (div_q),
      .mdc  (mdc),
      .rise (rise),
      .fall (fall)
   );

   mdio_frame_shift #(.PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept),
      .active (busy_q),
      .is_rd  (!cmd_wr),
      .phy    (cmd_phy),
      .rga    (cmd_reg),
      .wdata  (load_data),
      .rise   (rise),
      .fall   (fall),
      .mdio_i (mdio_i),
      .mdio_o (mdio_o),
      .mdio_oe(mdio_oe),
      .rdata  (rx_data),
      .done   (done)
   );
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk #(
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_we,
   input logic              cmd_go,
   input logic              data_we,
   input logic              busy,
   input logic              mdc,
   input logic              mdio_o,
   input logic              mdio_oe,
   input logic              wr_q,
   input logic [DATA_W-1:0] data_rdata
);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));

   a_r2_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_we && cmd_go));

   a_r3_mdc_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> busy);

   a_r5_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_q) |-> mdio_oe);

   a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rdata != $past(data_rdata)) |-> ($past(data_we && !busy) || $fell(busy)));

   a_r10_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_o != $past(mdio_o)) |-> ($fell(mdc) || $rose(busy)));
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_we    (cmd_we),
   .cmd_go    (cmd_go),
   .data_we   (data_we),
   .busy      (busy),
   .mdc       (mdc),
   .mdio_o    (mdio_o),
   .mdio_oe   (mdio_oe),
   .wr_q      (wr_q),
   .data_rdata(data_rdata)
);

// File: tb/mdio_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module mdio_cmd_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0, cmd_go = 1'b0, cmd_wr = 1'b0;
   logic [1:0]  cmd_div = '0;
   logic [4:0]  cmd_phy = '0, cmd_reg = '0;
   logic        data_we = 1'b0;
   logic [15:0] data_wdata = '0;
   logic [15:0] data_rdata;
   logic        busy, mdc, mdio_o, mdio_oe, mdio_i;
   logic        resp_drv = 1'b1;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   assign mdio_i = mdio_oe ? mdio_o : resp_drv;

   mdio_cmd_engine dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_go(cmd_go), .cmd_wr(cmd_wr),
      .cmd_div(cmd_div), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .data_we(data_we),
      .data_wdata(data_wdata), .data_rdata(data_rdata), .busy(busy), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // scoreboard queues
   logic [63:0] exp_frame_q[$];
   int          exp_oe_q[$];
   string       exp_req_q[$];
   realtime     exp_per_q[$];

   // monitor / responder state
   int          nbits = 0;
   int          oe_cnt = 0;
   int          unstable = 0;
   bit          op_rd = 1'b0;
   logic [63:0] cap = '0;
   logic [15:0] resp_val = '0;
   logic        hi_val = 1'b0;
   realtime     t_last = 0.0;
   realtime     per = 0.0;

   always @(posedge mdc) begin
      cap = {cap[62:0], mdio_i};
      if (mdio_oe) oe_cnt++;
      nbits++;
      hi_val = mdio_i;
      if (nbits == 2) per = $realtime - t_last;
      t_last = $realtime;
      if (nbits == 36) op_rd = (cap[1:0] == 2'b10);
      if (nbits == 64) begin
         if (exp_frame_q.size() == 0) begin
            check(1'b0, "R7", "unexpected frame", longint'(cap), 0);
         end else begin
            logic [63:0] ef;
            int          eo;
            string       er;
            realtime     ep;
            ef = exp_frame_q.pop_front();
            eo = exp_oe_q.pop_front();
            er = exp_req_q.pop_front();
            ep = exp_per_q.pop_front();
            check(cap === ef, "R4", "frame bits", longint'(cap), longint'(ef));
            check(oe_cnt == eo, er, "driven bit count", oe_cnt, eo);
            check(per == ep, "R3", "MDC period ps", longint'(per * 1000), longint'(ep * 1000));
            check(unstable == 0, "R10", "MDIO change while MDC high", unstable, 0);
         end
      end
   end

   always @(negedge mdc) begin
      if (op_rd && nbits == 47) resp_drv = 1'b0;
      else if (op_rd && nbits >= 48 && nbits <= 63) resp_drv = resp_val[63 - nbits];
      else resp_drv = 1'b1;
   end

   always @(negedge clk) begin
      if (mdc && (mdio_i !== hi_val)) unstable++;
   end

   task automatic xact(input bit rd, input logic [1:0] div, input logic [4:0] phy,
                       input logic [4:0] rga, input logic [15:0] wd,
                       input logic [15:0] rv, input bit inject);
      int cnt;
      int ratio;
      ratio = 16 << div;
      @(negedge clk);
      if (!rd) begin
         data_we = 1'b1; data_wdata = wd;
         @(negedge clk);
         data_we = 1'b0;
      end
      resp_val = rv; nbits = 0; oe_cnt = 0; op_rd = 1'b0; unstable = 0; cap = '0;
      exp_frame_q.push_back({32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rga, 2'b10,
                             (rd ? rv : wd)});
      exp_oe_q.push_back(rd ? 46 : 64);
      exp_req_q.push_back(rd ? "R6" : "R5");
      exp_per_q.push_back(ratio * 5.0);
      cmd_wr = !rd; cmd_div = div; cmd_phy = phy; cmd_reg = rga; cmd_go = 1'b1; cmd_we = 1'b1;
      @(negedge clk);
      cmd_we = 1'b0;
      cnt = 0;
      while (busy && cnt < 20000) begin
         cnt++;
         if (inject && cnt == 100) begin
            cmd_we = 1'b1; cmd_go = 1'b1; cmd_wr = rd; cmd_phy = ~phy; cmd_reg = ~rga;
            cmd_div = ~div; data_we = 1'b1; data_wdata = 16'hDEAD;
         end else if (inject && cnt == 101) begin
            cmd_we = 1'b0; data_we = 1'b0;
         end
         @(negedge clk);
      end
      check(cnt == 64 * ratio, "R2", "busy length", cnt, 64 * ratio);
      if (rd) check(data_rdata == rv, inject ? "R8" : "R6", "read data", data_rdata, rv);
      else    check(data_rdata == wd, inject ? "R8" : "R5", "data kept after write", data_rdata, wd);
      repeat (300) @(negedge clk);
      check(!busy && !mdc && !mdio_oe, "R3", "idle MDC low", {busy, mdc, mdio_oe}, 0);
      if (inject) check(nbits == 64, "R7", "single frame after ignored command", nbits, 64);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !mdc && !mdio_oe && data_rdata == 0, "R1", "reset state",
            {busy, mdc, mdio_oe, data_rdata}, 0);

      // R9: strobe without go bit
      cmd_we = 1'b1; cmd_go = 1'b0; cmd_wr = 1'b1;
      @(negedge clk);
      cmd_we = 1'b0;
      repeat (40) @(negedge clk);
      check(!busy && !mdc, "R9", "no start without go", {busy, mdc}, 0);

      // R5: preload while idle
      data_we = 1'b1; data_wdata = 16'h1234;
      @(negedge clk);
      data_we = 1'b0;
      check(data_rdata == 16'h1234, "R5", "data preload", data_rdata, 16'h1234);

      xact(1'b0, 2'd0, 5'h01, 5'h10, 16'hA5C3, 16'h0000, 1'b0);
      xact(1'b0, 2'd1, 5'h1F, 5'h00, 16'h8001, 16'h0000, 1'b0);
      xact(1'b0, 2'd2, 5'h0A, 5'h15, 16'h7FFE, 16'h0000, 1'b0);
      xact(1'b0, 2'd3, 5'h15, 5'h0A, 16'h0F0F, 16'h0000, 1'b0);
      xact(1'b1, 2'd0, 5'h03, 5'h02, 16'h0000, 16'hBEEF, 1'b0);
      xact(1'b1, 2'd1, 5'h10, 5'h1F, 16'h0000, 16'h8001, 1'b0);
      xact(1'b1, 2'd0, 5'h07, 5'h04, 16'h0000, 16'h3C5A, 1'b1);
      xact(1'b0, 2'd1, 5'h02, 5'h09, 16'hC0DE, 16'h0000, 1'b1);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule